// File: doc/BRIEF.md
# Switchable Triple-Copy Read Voter

The block sits between three redundant copies of a byte-wide memory and a processor read bus. In the default mode it returns the bitwise two-out-of-three majority of the three copies, so one faulty copy cannot corrupt a read. A command can switch it into pass-through mode, where it forwards the data of one chosen copy and ignores the other two. A command can also switch it back to voting.

On every read the block compares each copy with the voted value. It records a sticky per-copy mismatch flag, and a command clears these flags. Processor writes go to all three copies at the same time in every mode. A mode command that arrives while a read is in progress is held back until the read ends. This keeps the mode steady for the whole read.

Top module: `tmr_read_voter`

## Requirements
- R1: After reset, `mode` is 2'b00 (vote), `mismatch` is 3'b000, `rvalid` is 0 and `rdata` is 0.
- R2: When `rd_en` is sampled high at a clock edge and `mode` is 2'b00, `rdata` shows the bitwise majority (a&b)|(a&c)|(b&c) of `rd0`, `rd1` and `rd2` after that edge, and `rvalid` is 1 for that one cycle.
- R3: In vote mode, a read returns the data of the two agreeing copies whatever value the third copy carries.
- R4: With `mode` at 2'b01, 2'b10 or 2'b11, a read returns `rd0`, `rd1` or `rd2` unchanged.
- R5: When `mode_wr` is high at an edge where `rd_en` is low, `mode` takes the value of `mode_val` at that edge.
- R6: A mode command that arrives while `rd_en` is high does not change `mode` until the first edge at which `rd_en` is low. If several commands arrive before then, the newest one wins. A direct command at that edge wins over a held one.
- R7: On a read, bit i of `mismatch` is set if copy i differs from the voted value in any bit, in every mode. Set bits stay set.
- R8: `flag_clr` high at an edge clears `mismatch`. If a read happens at the same edge, only the mismatches of that read remain.
- R9: `mem_we` is 3'b111 whenever `wr_en` is high and 3'b000 otherwise. `mem_wdata` equals `wdata`. Both are combinational and do not depend on the mode.
- R10: At an edge with `rd_en` low, `rdata` holds its value, `rvalid` is 0 and `mismatch` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read in progress; consecutive high cycles form one read |
| rd0 | input | 8 | Read data from copy 0 |
| rd1 | input | 8 | Read data from copy 1 |
| rd2 | input | 8 | Read data from copy 2 |
| rdata | output | 8 | Registered read data to the processor |
| rvalid | output | 1 | High for one cycle after each sampled read |
| wr_en | input | 1 | Processor write strobe |
| wdata | input | 8 | Processor write data |
| mem_we | output | 3 | Write enables for the three copies |
| mem_wdata | output | 8 | Write data sent to all copies |
| mode_wr | input | 1 | Mode command strobe |
| mode_val | input | 2 | New mode: 00 vote, 01/10/11 forward copy 0/1/2 |
| flag_clr | input | 1 | Clear mismatch flags |
| mode | output | 2 | Active read mode |
| mismatch | output | 3 | Sticky per-copy disagreement flags |

## Verification
The bench puts a different corrupt value on each copy in turn. A voter with a wrong majority term would then leak that copy's garbage to `rdata`. It issues mode commands in the middle of a multi-cycle read and checks that `mode` stays put until `rd_en` drops and that the newest command wins. A design without the hold-back would switch sources partway through a read. It clears the flags in the same cycle as a mismatching read, which catches a clear that wipes the new flags or ignores the read. It also checks that idle cycles leave `rdata` and the flags untouched, which catches logic that samples the copies without a read.

// File: rtl/tmr_read_voter.sv
module tmr_read_voter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] rd0,
  input  logic [DW-1:0] rd1,
  input  logic [DW-1:0] rd2,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [2:0]    mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic          mode_wr,
  input  logic [1:0]    mode_val,
  input  logic          flag_clr,
  output logic [1:0]    mode,
  output logic [2:0]    mismatch
);
  localparam int NCOPY = 3;

  logic [DW-1:0] copy [NCOPY];
  logic [DW-1:0] voted, picked;
  logic [2:0]    differs;
  logic          held_v;
  logic [1:0]    held_m;

  assign copy[0] = rd0;
  assign copy[1] = rd1;
  assign copy[2] = rd2;

  assign voted = (rd0 & rd1) | (rd0 & rd2) | (rd1 & rd2);

  for (genvar i = 0; i < NCOPY; i++) begin : g_cmp
    assign differs[i] = |(copy[i] ^ voted);
  end

  always_comb begin
    case (mode)
      2'b01:   picked = rd0;
      2'b10:   picked = rd1;
      2'b11:   picked = rd2;
      default: picked = voted;
    endcase
  end

  assign mem_we    = {NCOPY{wr_en}};
  assign mem_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= 2'b00;
      held_v <= 1'b0;
      held_m <= 2'b00;
    end else if (rd_en) begin
      if (mode_wr) begin
        held_v <= 1'b1;
        held_m <= mode_val;
      end
    end else begin
      held_v <= 1'b0;
      if (mode_wr)     mode <= mode_val;
      else if (held_v) mode <= held_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      mismatch <= 3'b000;
    end else begin
      rvalid   <= rd_en;
      if (rd_en) rdata <= picked;
      mismatch <= (flag_clr ? 3'b000 : mismatch) | (rd_en ? differs : 3'b000);
    end
  end

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> $stable(mode));
  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((mismatch & $past(mismatch)) == $past(mismatch)));
  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rd_en) |=> (mismatch == 3'b000));
  assert_vote_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 2'b00 && rd0 == rd1) |=> (rdata == $past(rd0)));
  assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 2'b10) |=> (rdata == $past(rd1)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rvalid && $stable(rdata)));
  assert_write_fanout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mem_we == 3'b111 && mem_wdata == wdata));
endmodule

// File: tb/sim_tmr_read_voter.sv
module sim_tmr_read_voter;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, mode_wr = 0, flag_clr = 0;
  logic [7:0] rd0 = 0, rd1 = 0, rd2 = 0, wdata = 0;
  logic [1:0] mode_val = 0;
  logic [7:0] rdata, mem_wdata;
  logic rvalid;
  logic [2:0] mem_we, mismatch;
  logic [1:0] mode;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_read_voter u0 (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd0(rd0), .rd1(rd1), .rd2(rd2),
    .rdata(rdata), .rvalid(rvalid), .wr_en(wr_en), .wdata(wdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mode_wr(mode_wr), .mode_val(mode_val), .flag_clr(flag_clr),
    .mode(mode), .mismatch(mismatch));

  function automatic logic [7:0] maj(input logic [7:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic read1(input logic [7:0] a, b, c);
    rd_en = 1; rd0 = a; rd1 = b; rd2 = c;
    tick();
    rd_en = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1; mode_val = m;
    tick();
    mode_wr = 0;
    chk("R5 mode load", {6'd0, mode}, {6'd0, m});
  endtask

  task automatic clear_flags;
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 mode", {6'd0, mode}, 8'h00);
    chk("R1 mismatch", {5'd0, mismatch}, 8'h00);
    chk("R1 rvalid", {7'd0, rvalid}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
  endtask

  task automatic t_vote;
    read1(8'hF0, 8'h3C, 8'hAA);
    chk("R2 majority", rdata, maj(8'hF0, 8'h3C, 8'hAA));
    chk("R2 rvalid", {7'd0, rvalid}, 8'h01);
    tick();
    chk("R2 rvalid one cycle", {7'd0, rvalid}, 8'h00);
    clear_flags();
  endtask

  task automatic t_mask;
    read1(8'h5A, 8'h5A, 8'hFF);
    chk("R3 bad copy2", rdata, 8'h5A);
    read1(8'h00, 8'hC3, 8'hC3);
    chk("R3 bad copy0", rdata, 8'hC3);
    read1(8'h96, 8'h69, 8'h96);
    chk("R3 bad copy1", rdata, 8'h96);
    chk("R7 all copies flagged", {5'd0, mismatch}, 8'h07);
    clear_flags();
    chk("R8 cleared", {5'd0, mismatch}, 8'h00);
  endtask

  task automatic t_forward;
    set_mode(2'b01);
    read1(8'h11, 8'h22, 8'h22);
    chk("R4 copy0", rdata, 8'h11);
    set_mode(2'b10);
    read1(8'h33, 8'h44, 8'h33);
    chk("R4 copy1", rdata, 8'h44);
    set_mode(2'b11);
    read1(8'h55, 8'h55, 8'h77);
    chk("R4 copy2", rdata, 8'h77);
    chk("R7 flags in forward mode", {5'd0, mismatch}, 8'h07);
    set_mode(2'b00);
    clear_flags();
  endtask

  task automatic t_defer;
    rd_en = 1; rd0 = 8'h0F; rd1 = 8'h0F; rd2 = 8'h0F;
    mode_wr = 1; mode_val = 2'b01; tick();
    mode_val = 2'b10; tick();
    mode_wr = 0; rd0 = 8'hE1; tick();
    chk("R6 mode held in read", {6'd0, mode}, 8'h00);
    chk("R6 still voting", rdata, 8'h0F);
    rd_en = 0; tick();
    chk("R6 newest wins", {6'd0, mode}, 8'h02);
    rd_en = 1; mode_wr = 1; mode_val = 2'b01; tick();
    rd_en = 0; mode_val = 2'b11; tick();
    mode_wr = 0;
    chk("R6 direct beats held", {6'd0, mode}, 8'h03);
    set_mode(2'b00);
    clear_flags();
  endtask

  task automatic t_clr_read;
    read1(8'h01, 8'h00, 8'h00);
    chk("R7 copy0 flag", {5'd0, mismatch}, 8'h01);
    read1(8'h00, 8'h00, 8'h00);
    chk("R7 sticky", {5'd0, mismatch}, 8'h01);
    flag_clr = 1; read1(8'h00, 8'h00, 8'h80); flag_clr = 0;
    chk("R8 clear with read", {5'd0, mismatch}, 8'h04);
    clear_flags();
  endtask

  task automatic t_idle;
    read1(8'hAB, 8'hAB, 8'hAB);
    rd0 = 8'h00; rd1 = 8'hFF; rd2 = 8'h12;
    tick(); tick();
    chk("R10 rdata held", rdata, 8'hAB);
    chk("R10 rvalid low", {7'd0, rvalid}, 8'h00);
    chk("R10 flags unchanged", {5'd0, mismatch}, 8'h00);
  endtask

  task automatic t_write;
    set_mode(2'b10);
    wr_en = 1; wdata = 8'h9C; #1;
    chk("R9 we", {5'd0, mem_we}, 8'h07);
    chk("R9 wdata", mem_wdata, 8'h9C);
    wr_en = 0; #1;
    chk("R9 we off", {5'd0, mem_we}, 8'h00);
    set_mode(2'b00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    tick(); rst_n = 1; tick();
    t_reset();
    t_vote();
    t_mask();
    t_forward();
    t_defer();
    t_clr_read();
    t_idle();
    t_write();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule